// File: doc/BRIEF.md
# Switch-Header VLAN Tag Fixup

This block sits between the CPU port of an Ethernet switch and a host MAC and handles a 2-byte header that the switch puts in front of each frame. Frames leaving the switch (the receive path) lose that header. If such a frame carries an 802.1Q tag and its source port is not configured as a tagged port, the VLAN ID in the tag is replaced. The switch does not deliver a usable VID for untagged sources, so the block finds the real one in two steps: it reads the source port's default-table index, then reads the VID table at that index. Frames going toward the switch (the transmit path) get the 2-byte header added in front.

Both directions are byte-wide valid/ready streams with a last-byte flag. An input byte transfers on any rising edge where valid and ready are both high. An output stays stable for as long as valid is high and ready is low. Each path has one output register. Its input ready is high whenever that register is empty or is being drained in the same cycle, so the path runs at one byte per clock with no gaps. The lookup tables and the mode flag are loaded through a plain single-cycle write port. The VLAN mode decides whether headers are touched at all, and it is read once per frame, at the frame's first byte.

Top module: `vtag_fixup`

## Requirements
- R1: With VLAN mode off, every frame leaves each path byte for byte identical to how it entered, including its first two bytes and its last flag.
- R2: With VLAN mode on, the receive path removes the first two bytes of each frame and passes the remaining bytes in order, with the last flag on the final byte.
- R3: The source port is bits [3:0] of the first header byte, and bits [7:4] are ignored. A port number of NPORTS or above never gets a fixup.
- R4: The fixup applies only when the bytes at offsets 12 and 13 of the stripped frame are 0x81 and 0x00. Any other pair leaves the frame unchanged apart from the stripped header.
- R5: If the source port's bit is set in the tagged-port mask, the frame passes unchanged apart from the stripped header.
- R6: The replacement VID is vid_table[pvid[port]]. Stripped offset 14 keeps its bits [7:4] and takes VID[11:8] in bits [3:0]. Offset 15 becomes VID[7:0].
- R7: With VLAN mode on, the transmit path sends 0x10 and then 0x80 before the first byte of each frame, and the last flag stays on the frame's own final byte.
- R8: After reset, VID table entry i holds i, every pvid is 0, the tagged mask is 0, VLAN mode is off, and both output valids are low.
- R9: While an output has valid high and ready low, its data, valid and last do not change, and no input byte is lost or duplicated under any ready pattern.
- R10: A config write uses cfg_addr[8:7] to choose the target. 0 writes VID entry cfg_addr[6:0] with cfg_wdata[11:0]. 1 writes the pvid of port cfg_addr[2:0] with cfg_wdata[6:0]. 2 writes the tagged mask from cfg_wdata[7:0], where bit n is port n. 3 writes VLAN mode from cfg_wdata[0].
- R11: The VLAN mode is sampled at each frame's first byte. Changing it during a frame has no effect on that frame.
- R12: With VLAN mode on, a receive frame of one or two bytes produces no output, and the frame that follows it is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 9 | Config target select and index |
| cfg_wdata | input | 12 | Config write data |
| rx_s_tdata | input | 8 | Receive input byte (from the switch) |
| rx_s_tvalid | input | 1 | Receive input valid |
| rx_s_tlast | input | 1 | Receive input last byte of frame |
| rx_s_tready | output | 1 | Receive input ready |
| rx_m_tdata | output | 8 | Receive output byte (to the host) |
| rx_m_tvalid | output | 1 | Receive output valid |
| rx_m_tlast | output | 1 | Receive output last byte of frame |
| rx_m_tready | input | 1 | Receive output ready |
| tx_s_tdata | input | 8 | Transmit input byte (from the host) |
| tx_s_tvalid | input | 1 | Transmit input valid |
| tx_s_tlast | input | 1 | Transmit input last byte of frame |
| tx_s_tready | output | 1 | Transmit input ready |
| tx_m_tdata | output | 8 | Transmit output byte (to the switch) |
| tx_m_tvalid | output | 1 | Transmit output valid |
| tx_m_tlast | output | 1 | Transmit output last byte of frame |
| tx_m_tready | input | 1 | Transmit output ready |

## Verification
The receive fixup is driven with frames that vary one condition at a time: the tag identifier bytes (a correct 0x8100, a wrong second byte, a different EtherType), the tagged-mask bit, the port nibble (noise in the upper bits, an out-of-range port), and table entries at reset values, at rewritten values and at the top index. Each variant separates one gate of the rewrite from the others. The priority nibble of the original TCI is chosen so that a rewrite which clobbers it shows up. Some frames run under a stalling output ready, which exposes lost or repeated bytes. Three more cases cover boundaries: the mode flag is toggled in the middle of a frame, sub-header frames are sent just ahead of a normal one, and single-byte transmit frames are sent.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int VID_W   = 12;
  localparam int BYTE_W  = 8;
  localparam int HDR_LEN = 2;

  localparam logic [7:0] HDR_B0  = 8'h10;
  localparam logic [7:0] HDR_B1  = 8'h80;
  localparam logic [7:0] TPID_HI = 8'h81;
  localparam logic [7:0] TPID_LO = 8'h00;

  // Input-byte indices on the receive side (stripped offset + header length)
  localparam int IX_TPID_HI = HDR_LEN + 12;
  localparam int IX_TPID_LO = HDR_LEN + 13;
  localparam int IX_TCI_HI  = HDR_LEN + 14;
  localparam int IX_TCI_LO  = HDR_LEN + 15;
  localparam int IX_SAT     = IX_TCI_LO + 1;

  typedef enum logic [1:0] {
    SEL_VID  = 2'd0,
    SEL_PVID = 2'd1,
    SEL_TAGM = 2'd2,
    SEL_MODE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    TX_HDR0 = 2'd0,
    TX_HDR1 = 2'd1,
    TX_BODY = 2'd2
  } tx_st_e;
endpackage

// File: rtl/vtag_cfg.sv
module vtag_cfg
  import vtag_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int IDX_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IDX_W+1:0]          cfg_addr,
  input  logic [VID_W-1:0]          cfg_wdata,
  input  logic [$clog2(NPORTS)-1:0] port_sel,
  output logic [VID_W-1:0]          port_vid,
  output logic [NPORTS-1:0]         tag_mask,
  output logic                      vlan_en
);
  localparam int NVID   = 1 << IDX_W;
  localparam int PORT_W = $clog2(NPORTS);

  logic [VID_W-1:0] vid_tab [NVID];
  logic [IDX_W-1:0] pvid    [NPORTS];
  cfg_sel_e         sel;

  assign sel = cfg_sel_e'(cfg_addr[IDX_W+1:IDX_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVID; i++) vid_tab[i] <= VID_W'(i);
      for (int p = 0; p < NPORTS; p++) pvid[p] <= '0;
      tag_mask <= '0;
      vlan_en  <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        SEL_VID:  vid_tab[cfg_addr[IDX_W-1:0]] <= cfg_wdata;
        SEL_PVID: if (int'(cfg_addr[PORT_W-1:0]) < NPORTS)
                    pvid[cfg_addr[PORT_W-1:0]] <= cfg_wdata[IDX_W-1:0];
        SEL_TAGM: tag_mask <= cfg_wdata[NPORTS-1:0];
        default:  vlan_en  <= cfg_wdata[0];
      endcase
    end
  end

  // two-level lookup: port -> default index -> VID
  assign port_vid = vid_tab[pvid[port_sel]];

  p_cfg_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel == SEL_MODE) |=> (vlan_en == $past(cfg_wdata[0])));
  p_cfg_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel == SEL_TAGM) |=> (tag_mask == $past(cfg_wdata[NPORTS-1:0])));
endmodule

// File: rtl/vtag_rx.sv
module vtag_rx
  import vtag_pkg::*;
#(
  parameter int NPORTS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vlan_en,
  input  logic [NPORTS-1:0]         tag_mask,
  input  logic [VID_W-1:0]          port_vid,
  output logic [$clog2(NPORTS)-1:0] port_sel,
  input  logic [BYTE_W-1:0]         s_tdata,
  input  logic                      s_tvalid,
  input  logic                      s_tlast,
  output logic                      s_tready,
  output logic [BYTE_W-1:0]         m_tdata,
  output logic                      m_tvalid,
  output logic                      m_tlast,
  input  logic                      m_tready
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int IW     = $clog2(IX_SAT + 1);

  logic [IW-1:0] idx;
  logic          fm;        // mode latched at byte 0
  logic [3:0]    hdr_port;
  logic          tp_hi, tp_lo;
  logic          load, acc, mode_now, drop, fix, port_ok;
  logic [7:0]    out_byte;

  assign load     = !m_tvalid || m_tready;
  assign s_tready = load;
  assign acc      = s_tvalid && load;
  assign mode_now = (idx == '0) ? vlan_en : fm;
  assign drop     = mode_now && (int'(idx) < HDR_LEN);
  assign port_sel = hdr_port[PORT_W-1:0];
  assign port_ok  = int'(hdr_port) < NPORTS;
  assign fix      = fm && tp_hi && tp_lo && port_ok && !tag_mask[port_sel];

  always_comb begin
    out_byte = s_tdata;
    if (fix && idx == IW'(IX_TCI_HI)) out_byte = {s_tdata[7:4], port_vid[11:8]};
    if (fix && idx == IW'(IX_TCI_LO)) out_byte = port_vid[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; fm <= 1'b0; hdr_port <= '0; tp_hi <= 1'b0; tp_lo <= 1'b0;
    end else if (acc) begin
      if (idx == '0) begin
        fm       <= vlan_en;
        hdr_port <= s_tdata[3:0];
      end
      if (idx == IW'(IX_TPID_HI)) tp_hi <= (s_tdata == TPID_HI);
      if (idx == IW'(IX_TPID_LO)) tp_lo <= (s_tdata == TPID_LO);
      if (s_tlast)                idx <= '0;
      else if (idx != IW'(IX_SAT)) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0; m_tdata <= '0; m_tlast <= 1'b0;
    end else if (acc && !drop) begin
      m_tvalid <= 1'b1; m_tdata <= out_byte; m_tlast <= s_tlast;
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  p_rx_hdr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && mode_now && int'(idx) < HDR_LEN) |=> !m_tvalid);
  p_rx_frame_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> (idx == '0));
endmodule

// File: rtl/vtag_tx.sv
module vtag_tx
  import vtag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vlan_en,
  input  logic [BYTE_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [BYTE_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready
);
  tx_st_e      st, st_nxt;
  logic        load, ld;
  logic [7:0]  d_nxt;
  logic        l_nxt;

  assign load = !m_tvalid || m_tready;

  always_comb begin
    s_tready = 1'b0; ld = 1'b0; d_nxt = s_tdata; l_nxt = s_tlast; st_nxt = st;
    case (st)
      TX_HDR0: begin
        if (vlan_en) begin
          ld = s_tvalid && load; d_nxt = HDR_B0; l_nxt = 1'b0; st_nxt = TX_HDR1;
        end else begin
          s_tready = load; ld = s_tvalid && load;
          st_nxt = s_tlast ? TX_HDR0 : TX_BODY;
        end
      end
      TX_HDR1: begin
        ld = load; d_nxt = HDR_B1; l_nxt = 1'b0; st_nxt = TX_BODY;
      end
      default: begin
        s_tready = load; ld = s_tvalid && load;
        st_nxt = s_tlast ? TX_HDR0 : TX_BODY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_HDR0; m_tvalid <= 1'b0; m_tdata <= '0; m_tlast <= 1'b0;
    end else if (ld) begin
      st <= st_nxt; m_tvalid <= 1'b1; m_tdata <= d_nxt; m_tlast <= l_nxt;
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  p_tx_first_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_HDR1) |-> (m_tvalid && m_tdata == HDR_B0 && !m_tlast));
  p_tx_second_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_BODY && $past(st) == TX_HDR1) |-> (m_tdata == HDR_B1 && !m_tlast));
endmodule

// File: rtl/vtag_fixup.sv
module vtag_fixup
  import vtag_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W+1:0] cfg_addr,
  input  logic [VID_W-1:0] cfg_wdata,
  input  logic [7:0]       rx_s_tdata,
  input  logic             rx_s_tvalid,
  input  logic             rx_s_tlast,
  output logic             rx_s_tready,
  output logic [7:0]       rx_m_tdata,
  output logic             rx_m_tvalid,
  output logic             rx_m_tlast,
  input  logic             rx_m_tready,
  input  logic [7:0]       tx_s_tdata,
  input  logic             tx_s_tvalid,
  input  logic             tx_s_tlast,
  output logic             tx_s_tready,
  output logic [7:0]       tx_m_tdata,
  output logic             tx_m_tvalid,
  output logic             tx_m_tlast,
  input  logic             tx_m_tready
);
  localparam int PORT_W = $clog2(NPORTS);

  logic                vlan_en;
  logic [NPORTS-1:0]   tag_mask;
  logic [VID_W-1:0]    port_vid;
  logic [PORT_W-1:0]   port_sel;

  vtag_cfg #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .port_sel(port_sel), .port_vid(port_vid),
    .tag_mask(tag_mask), .vlan_en(vlan_en)
  );

  vtag_rx #(.NPORTS(NPORTS)) u_rx (
    .clk(clk), .rst_n(rst_n), .vlan_en(vlan_en), .tag_mask(tag_mask),
    .port_vid(port_vid), .port_sel(port_sel),
    .s_tdata(rx_s_tdata), .s_tvalid(rx_s_tvalid), .s_tlast(rx_s_tlast),
    .s_tready(rx_s_tready), .m_tdata(rx_m_tdata), .m_tvalid(rx_m_tvalid),
    .m_tlast(rx_m_tlast), .m_tready(rx_m_tready)
  );

  vtag_tx u_tx (
    .clk(clk), .rst_n(rst_n), .vlan_en(vlan_en),
    .s_tdata(tx_s_tdata), .s_tvalid(tx_s_tvalid), .s_tlast(tx_s_tlast),
    .s_tready(tx_s_tready), .m_tdata(tx_m_tdata), .m_tvalid(tx_m_tvalid),
    .m_tlast(tx_m_tlast), .m_tready(tx_m_tready)
  );
endmodule

// File: tb/vtag_fixup_tb_top.sv
`timescale 1ns/1ps
module vtag_fixup_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [7:0] rx_s_tdata = '0, tx_s_tdata = '0;
  logic rx_s_tvalid = 1'b0, rx_s_tlast = 1'b0, rx_m_tready = 1'b1;
  logic tx_s_tvalid = 1'b0, tx_s_tlast = 1'b0, tx_m_tready = 1'b1;
  logic rx_s_tready, rx_m_tvalid, rx_m_tlast, tx_s_tready, tx_m_tvalid, tx_m_tlast;
  logic [7:0] rx_m_tdata, tx_m_tdata;

  always #2.5 clk = ~clk;

  vtag_fixup dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] in_b [64];
  bit         lst  [64];
  int         in_n;
  logic [7:0] exp_b [64];
  int         exp_n;
  logic [7:0] got_b [64];
  int         got_n;

  bit         sh_mode = 0;
  logic [7:0] sh_tag = '0;
  logic [6:0] sh_pvid [8];
  logic [11:0] sh_vid [128];

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [6:0] ix, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {sel, ix}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask
  task automatic set_mode(input bit m);  cfg_wr(2'd3, 7'd0, {11'd0, m}); sh_mode = m; endtask
  task automatic set_tag(input logic [7:0] m); cfg_wr(2'd2, 7'd0, {4'd0, m}); sh_tag = m; endtask
  task automatic set_pvid(input int p, input logic [6:0] v);
    cfg_wr(2'd1, 7'(p), {5'd0, v}); sh_pvid[p] = v;
  endtask
  task automatic set_vid(input int i, input logic [11:0] v);
    cfg_wr(2'd0, 7'(i), v); sh_vid[i] = v;
  endtask

  task automatic mk_eth(input logic [7:0] hb0, input logic [7:0] t12, input logic [7:0] t13,
                        input logic [15:0] tci, input int plen);
    in_b[0] = hb0; in_b[1] = 8'h5A;
    for (int k = 0; k < 12; k++) in_b[2+k] = 8'h20 + 8'(k);
    in_b[14] = t12; in_b[15] = t13; in_b[16] = tci[15:8]; in_b[17] = tci[7:0];
    for (int k = 0; k < plen; k++) in_b[18+k] = 8'hC0 + 8'(k);
    in_n = 18 + plen;
    for (int k = 0; k < 64; k++) lst[k] = (k == in_n - 1);
  endtask

  task automatic mk_tx(input int n);
    in_n = n;
    for (int k = 0; k < 64; k++) begin
      in_b[k] = 8'h30 + 8'(k); lst[k] = (k == n - 1);
    end
  endtask

  // reference for the receive path, from the requirements
  task automatic model_rx();
    logic [3:0] p;
    logic [11:0] v;
    if (!sh_mode) begin
      exp_n = in_n;
      for (int k = 0; k < in_n; k++) exp_b[k] = in_b[k];
    end else begin
      exp_n = in_n - 2;
      for (int k = 0; k < exp_n; k++) exp_b[k] = in_b[k+2];
      p = in_b[0][3:0];
      if (exp_b[12] == 8'h81 && exp_b[13] == 8'h00 && p < 8 && !sh_tag[p[2:0]]) begin
        v = sh_vid[sh_pvid[p[2:0]]];
        exp_b[14] = {exp_b[14][7:4], v[11:8]};
        exp_b[15] = v[7:0];
      end
    end
  endtask

  task automatic model_tx();
    if (!sh_mode) begin
      exp_n = in_n;
      for (int k = 0; k < in_n; k++) exp_b[k] = in_b[k];
    end else begin
      exp_n = in_n + 2; exp_b[0] = 8'h10; exp_b[1] = 8'h80;
      for (int k = 0; k < in_n; k++) exp_b[k+2] = in_b[k];
    end
  endtask

  task automatic drive(input bit side);
    for (int i = 0; i < in_n; i++) begin
      @(negedge clk);
      if (side == 0) begin rx_s_tvalid = 1; rx_s_tdata = in_b[i]; rx_s_tlast = lst[i]; end
      else           begin tx_s_tvalid = 1; tx_s_tdata = in_b[i]; tx_s_tlast = lst[i]; end
      #1;
      while (!(side == 0 ? rx_s_tready : tx_s_tready)) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    rx_s_tvalid = 0; tx_s_tvalid = 0;
  endtask

  task automatic collect(input bit side, input bit bp);
    bit fin = 0;
    int cyc = 0;
    got_n = 0;
    while (!fin && cyc < 400) begin
      @(negedge clk);
      if (side == 0) rx_m_tready = bp ? (cyc % 3 != 1) : 1'b1;
      else           tx_m_tready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (side == 0 && rx_m_tvalid && rx_m_tready) begin
        got_b[got_n] = rx_m_tdata; got_n++; fin = rx_m_tlast;
      end
      if (side == 1 && tx_m_tvalid && tx_m_tready) begin
        got_b[got_n] = tx_m_tdata; got_n++; fin = tx_m_tlast;
      end
      cyc++;
    end
    @(negedge clk);
    rx_m_tready = 1; tx_m_tready = 1;
  endtask

  task automatic compare(input string req, input string name);
    checks++;
    if (got_n != exp_n) begin
      fails++;
      $display("FAIL %s %s: length got %0d exp %0d", req, name, got_n, exp_n);
      return;
    end
    for (int k = 0; k < exp_n; k++)
      if (got_b[k] !== exp_b[k]) begin
        fails++;
        $display("FAIL %s %s: byte %0d got %h exp %h", req, name, k, got_b[k], exp_b[k]);
        return;
      end
  endtask

  task automatic run(input bit side, input bit bp, input string req, input string name);
    if (side == 0) model_rx(); else model_tx();
    fork
      drive(side);
      collect(side, bp);
    join
    compare(req, name);
  endtask

  task automatic t_reset();
    checks++;
    if (rx_m_tvalid !== 0 || tx_m_tvalid !== 0 || rx_s_tready !== 1) begin
      fails++;
      $display("FAIL R8 reset: got rxv=%b txv=%b rdy=%b exp 0 0 1",
               rx_m_tvalid, tx_m_tvalid, rx_s_tready);
    end
  endtask

  task automatic t_bypass();
    mk_eth(8'h02, 8'h81, 8'h00, 16'hA123, 4); run(0, 0, "R1", "rx bypass");
    mk_tx(9);                                 run(1, 1, "R1", "tx bypass");
  endtask

  task automatic t_reset_tables();
    set_mode(1);
    mk_eth(8'h02, 8'h81, 8'h00, 16'hA123, 3); run(0, 0, "R8", "reset pvid/vid");
    set_pvid(3, 7'd5);
    mk_eth(8'h03, 8'h81, 8'h00, 16'h7FFF, 3); run(0, 0, "R10", "pvid write, identity vid");
  endtask

  task automatic t_vid();
    set_vid(5, 12'hABC);
    mk_eth(8'h03, 8'h81, 8'h00, 16'h5FFF, 6); run(0, 1, "R6", "vid rewrite stalled");
    set_pvid(6, 7'd127); set_vid(127, 12'h001);
    mk_eth(8'h06, 8'h81, 8'h00, 16'hE0F0, 2); run(0, 0, "R6", "top table index");
  endtask

  task automatic t_tpid();
    mk_eth(8'h03, 8'h08, 8'h00, 16'h5FFF, 2); run(0, 0, "R4", "ipv4 type");
    mk_eth(8'h03, 8'h81, 8'h01, 16'h5FFF, 2); run(0, 0, "R4", "tpid low mismatch");
    mk_eth(8'h03, 8'h88, 8'h00, 16'h5FFF, 2); run(0, 1, "R4", "tpid high mismatch");
  endtask

  task automatic t_tagged();
    set_tag(8'h08);
    mk_eth(8'h03, 8'h81, 8'h00, 16'h5FFF, 2); run(0, 0, "R5", "tagged port untouched");
    mk_eth(8'h02, 8'h81, 8'h00, 16'h5FFF, 2); run(0, 0, "R5", "untagged neighbour fixed");
    set_tag(8'h00);
  endtask

  task automatic t_port();
    mk_eth(8'hB3, 8'h81, 8'h00, 16'h4321, 2); run(0, 0, "R3", "upper nibble ignored");
    mk_eth(8'h09, 8'h81, 8'h00, 16'h4321, 2); run(0, 0, "R3", "port out of range");
  endtask

  task automatic t_tx();
    mk_tx(12); run(1, 1, "R7", "tx header stalled");
    mk_tx(1);  run(1, 0, "R7", "tx one byte frame");
  endtask

  task automatic t_short();
    mk_eth(8'h03, 8'h81, 8'h00, 16'h1234, 2);
    model_rx();
    for (int k = in_n - 1; k >= 0; k--) in_b[k+3] = in_b[k];
    in_b[0] = 8'h03; in_b[1] = 8'h44; in_b[2] = 8'h05;
    in_n = in_n + 3;
    for (int k = 0; k < 64; k++) lst[k] = (k == 1 || k == 2 || k == in_n - 1);
    fork
      drive(0);
      collect(0, 0);
    join
    compare("R12", "short frames dropped");
  endtask

  task automatic t_midframe();
    mk_eth(8'h03, 8'h81, 8'h00, 16'h9000, 8);
    model_rx();
    fork
      drive(0);
      collect(0, 1);
      begin repeat (4) @(negedge clk); cfg_wr(2'd3, 7'd0, 12'd0); end
    join
    sh_mode = 0;
    compare("R11", "rx mode off midframe");
    set_mode(1);
    mk_tx(10);
    model_tx();
    fork
      drive(1);
      collect(1, 0);
      begin repeat (5) @(negedge clk); cfg_wr(2'd3, 7'd0, 12'd0); end
    join
    sh_mode = 0;
    compare("R11", "tx mode off midframe");
    mk_eth(8'h03, 8'h81, 8'h00, 16'h9000, 2); run(0, 0, "R1", "mode off after frame");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) sh_vid[i] = 12'(i);
    for (int p = 0; p < 8; p++) sh_pvid[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_reset_tables();
    t_vid();
    t_tpid();
    t_tagged();
    t_port();
    t_tx();
    t_short();
    t_midframe();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule